// File: doc/BRIEF.md
# Dual-Clock Compare Timer

This block is a 32-bit up-counter with a single compare channel. Software reaches it through a small register port that runs on the bus clock. The counter itself runs on a separate counter clock, which has no fixed phase relation to the bus clock and can stay running while the bus side is idle. The counter advances on a prescaled tick and returns to zero after it reaches a programmable modulo value. When the channel is armed for software compare and the count reaches the loaded compare value, a status flag is set. An interrupt output follows that flag while the channel's interrupt enable is set.

Every write that affects counter-domain state crosses the clock boundary through one toggle request/acknowledge handshake. These are the control, counter, modulo, channel-control and channel-value registers. A busy output is high while such a write is in flight. A write to any of these registers that arrives while busy is high is dropped. The counter value reaches the bus side through a continuous snapshot loop, so a counter read always returns a coherent, recently captured value. Match events return to the bus side as a synchronized toggle. The flag register itself lives in the bus domain.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, the register reads are: control 0, counter 0, modulo 0xFFFFFFFF, status 0, channel control 0, channel value 0. The interrupt and busy outputs are low.
- R2: Control bits 4:3 hold the clock mode. Code 01 lets the counter advance on each prescaled tick. Code 00 (and the unused codes 10 and 11) holds the count unchanged.
- R3: Control bits 2:0 hold the prescale value p. In run mode the counter advances once every 2^p counter-clock cycles.
- R4: Any write to the counter register at offset 0x14 sets the count to zero, whatever the written data.
- R5: On a tick where the count equals the modulo value (offset 0x18), the count returns to zero. Otherwise it increments. A modulo of 0 keeps the count at 0.
- R6: Status bit 0 (offset 0x1C) is set on the tick where the count changes to a value equal to the channel value (offset 0x24). This happens only while channel-control bits 5:2 (offset 0x20) hold code 0x4. There is one set per such tick, and code 0 never sets the flag.
- R7: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged.
- R8: The interrupt output is high exactly while the flag is set and channel-control bit 6 is 1.
- R9: A write to offset 0x10, 0x14, 0x18, 0x20 or 0x24 raises busy from the next bus cycle until the counter domain has accepted it. While busy is high, further writes to these offsets are ignored.
- R10: A read strobe returns data with a valid pulse one bus cycle later. Register offsets are control 0x10, counter 0x14, modulo 0x18, status 0x1C, channel control 0x20 and channel value 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| cnt_clk | input | 1 | Counter clock, asynchronous to bus_clk |
| cnt_rst_n | input | 1 | Active-low asynchronous reset, counter domain |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read data valid, one cycle after reg_rd_en |
| reg_busy | output | 1 | Counter-domain write in flight |
| irq_o | output | 1 | Channel interrupt |

## Verification
The counter is run at prescale 0 and at prescale 3 over measured intervals. A stop-mode interval is also run. Comparing each final count with the elapsed counter-clock cycles separates a wrong divide ratio from a counter that ignores the stop code. Compare is tried with a full-range modulo, where exactly one match is expected and no second flag may appear. It is also tried with a small modulo, where the flag must return on every pass, and with the channel disabled, where it must never set. Together these separate once-per-match behaviour from level-triggered or mode-blind compare. The interrupt-enable bit is toggled with the flag held. Back-to-back modulo writes check that a write landing while busy is high is dropped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register byte offsets
    localparam int unsigned OFS_CTRL   = 32'h10;
    localparam int unsigned OFS_COUNT  = 32'h14;
    localparam int unsigned OFS_MODULO = 32'h18;
    localparam int unsigned OFS_STATUS = 32'h1C;
    localparam int unsigned OFS_CHCTL  = 32'h20;
    localparam int unsigned OFS_CHVAL  = 32'h24;

    // Field codes
    localparam logic [1:0] CMODE_RUN    = 2'b01;
    localparam logic [3:0] CHMODE_SWCMP = 4'h4;

    // Kind of a write crossing into the counter domain
    typedef enum logic [2:0] {
        WK_CTRL   = 3'd0,
        WK_COUNT  = 3'd1,
        WK_MODULO = 3'd2,
        WK_CHCTL  = 3'd3,
        WK_CHVAL  = 3'd4
    } wr_kind_e;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PSC_W  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    // write handshake, sink side
    input  logic              hs_req_tgl_i,
    input  wr_kind_e          hs_kind_i,
    input  logic [DATA_W-1:0] hs_data_i,
    output logic              hs_ack_tgl_o,
    // counter snapshot, source side
    output logic              snap_req_tgl_o,
    output logic [DATA_W-1:0] snap_data_o,
    input  logic              snap_ack_tgl_i,
    // match event toggle
    output logic              match_tgl_o
);

    localparam int unsigned DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [1:0]        cmode;
        logic [PSC_W-1:0]  psc;
        logic              cmp_en;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] modv;
        logic [DATA_W-1:0] chval;
        logic [DIV_W-1:0]  div;
        logic              hs_ack;
        logic              snap_req;
        logic [DATA_W-1:0] snap;
        logic              match_tgl;
        logic              match;
    } core_st_t;

    core_st_t s_d, s_q;

    logic [1:0]        sync_q;
    logic              req_s, sack_s;
    logic              run, tick, apply;
    logic [DIV_W-1:0]  div_mask;
    logic [DATA_W-1:0] cnt_nxt;

    tmr_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({hs_req_tgl_i, snap_ack_tgl_i}),
        .q_o  (sync_q)
    );
    assign req_s  = sync_q[1];
    assign sack_s = sync_q[0];

    always_comb begin
        s_d      = s_q;
        s_d.match = 1'b0;

        run      = (s_q.cmode == CMODE_RUN);
        div_mask = ~({DIV_W{1'b1}} << s_q.psc);
        tick     = run && ((s_q.div & div_mask) == div_mask);
        apply    = (req_s != s_q.hs_ack);
        cnt_nxt  = (s_q.cnt == s_q.modv) ? '0 : s_q.cnt + 1'b1;

        s_d.div = run ? s_q.div + 1'b1 : '0;

        if (apply) begin
            s_d.hs_ack = req_s;
            case (hs_kind_i)
                WK_CTRL: begin
                    s_d.cmode = hs_data_i[4:3];
                    s_d.psc   = hs_data_i[PSC_W-1:0];
                    s_d.div   = '0;
                end
                WK_COUNT:  s_d.cnt    = '0;
                WK_MODULO: s_d.modv   = hs_data_i;
                WK_CHCTL:  s_d.cmp_en = (hs_data_i[5:2] == CHMODE_SWCMP);
                WK_CHVAL:  s_d.chval  = hs_data_i;
                default: ;
            endcase
        end else if (tick) begin
            s_d.cnt = cnt_nxt;
            if (s_q.cmp_en && (cnt_nxt == s_q.chval) && (cnt_nxt != s_q.cnt)) begin
                s_d.match     = 1'b1;
                s_d.match_tgl = ~s_q.match_tgl;
            end
        end

        // free-running snapshot loop toward the bus domain
        if (sack_s == s_q.snap_req) begin
            s_d.snap     = s_q.cnt;
            s_d.snap_req = ~s_q.snap_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.modv <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_ack_tgl_o   = s_q.hs_ack;
    assign snap_req_tgl_o = s_q.snap_req;
    assign snap_data_o    = s_q.snap;
    assign match_tgl_o    = s_q.match_tgl;

    // R5: a tick at the modulo value returns the count to zero
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !apply && (s_q.cnt == s_q.modv)) |=> (s_q.cnt == '0));

    // R2: outside run mode the count holds unless software clears it
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !apply) |=> $stable(s_q.cnt));

    // R6: a match is a single pulse
    assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match |=> !s_q.match);

    // R6: a match pulse only with compare armed and count equal to channel value
    assert_match_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match |-> (s_q.cmp_en && (s_q.cnt == s_q.chval)));

endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PSC_W  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              irq_o,
    // write handshake, source side
    output logic              hs_req_tgl_o,
    output wr_kind_e          hs_kind_o,
    output logic [DATA_W-1:0] hs_data_o,
    input  logic              hs_ack_tgl_i,
    // counter snapshot, sink side
    input  logic              snap_req_tgl_i,
    input  logic [DATA_W-1:0] snap_data_i,
    output logic              snap_ack_tgl_o,
    // match event toggle
    input  logic              match_tgl_i
);

    typedef struct packed {
        logic [1:0]        cmode;
        logic [PSC_W-1:0]  psc;
        logic [DATA_W-1:0] modv;
        logic              chie;
        logic [3:0]        chmode;
        logic [DATA_W-1:0] chval;
        logic              flag;
        logic [DATA_W-1:0] cnt_view;
        logic              hs_req;
        wr_kind_e          hs_kind;
        logic [DATA_W-1:0] hs_data;
        logic              snap_ack;
        logic              match_seen;
        logic [DATA_W-1:0] rdata;
        logic              rd_valid;
    } bus_st_t;

    bus_st_t s_d, s_q;

    logic [2:0] sync_q;
    logic       ack_s, sreq_s, match_s;
    logic       sel_ctrl, sel_count, sel_mod, sel_stat, sel_chctl, sel_chval;
    logic       hs_hit, accept, match_evt;
    logic [DATA_W-1:0] rd_mux;

    tmr_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({hs_ack_tgl_i, snap_req_tgl_i, match_tgl_i}),
        .q_o  (sync_q)
    );
    assign ack_s   = sync_q[2];
    assign sreq_s  = sync_q[1];
    assign match_s = sync_q[0];

    assign busy_o = (s_q.hs_req != ack_s);

    always_comb begin
        sel_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
        sel_count = (addr_i == ADDR_W'(OFS_COUNT));
        sel_mod   = (addr_i == ADDR_W'(OFS_MODULO));
        sel_stat  = (addr_i == ADDR_W'(OFS_STATUS));
        sel_chctl = (addr_i == ADDR_W'(OFS_CHCTL));
        sel_chval = (addr_i == ADDR_W'(OFS_CHVAL));

        hs_hit    = wr_en_i && (sel_ctrl || sel_count || sel_mod || sel_chctl || sel_chval);
        accept    = hs_hit && !busy_o;
        match_evt = (match_s != s_q.match_seen);

        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux[4:3]       = s_q.cmode;
            rd_mux[PSC_W-1:0] = s_q.psc;
        end
        if (sel_count) rd_mux = s_q.cnt_view;
        if (sel_mod)   rd_mux = s_q.modv;
        if (sel_stat)  rd_mux[0] = s_q.flag;
        if (sel_chctl) begin
            rd_mux[6]   = s_q.chie;
            rd_mux[5:2] = s_q.chmode;
        end
        if (sel_chval) rd_mux = s_q.chval;

        s_d            = s_q;
        s_d.rd_valid   = rd_en_i;
        s_d.match_seen = match_s;
        if (rd_en_i) s_d.rdata = rd_mux;

        if (accept) begin
            s_d.hs_req  = ~s_q.hs_req;
            s_d.hs_data = wdata_i;
            if (sel_ctrl) begin
                s_d.hs_kind = WK_CTRL;
                s_d.cmode   = wdata_i[4:3];
                s_d.psc     = wdata_i[PSC_W-1:0];
            end else if (sel_count) begin
                s_d.hs_kind = WK_COUNT;
            end else if (sel_mod) begin
                s_d.hs_kind = WK_MODULO;
                s_d.modv    = wdata_i;
            end else if (sel_chctl) begin
                s_d.hs_kind = WK_CHCTL;
                s_d.chie    = wdata_i[6];
                s_d.chmode  = wdata_i[5:2];
            end else begin
                s_d.hs_kind = WK_CHVAL;
                s_d.chval   = wdata_i;
            end
        end

        if (wr_en_i && sel_stat && wdata_i[0]) s_d.flag = 1'b0;
        if (match_evt)                          s_d.flag = 1'b1;

        if (sreq_s != s_q.snap_ack) begin
            s_d.cnt_view = snap_data_i;
            s_d.snap_ack = sreq_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.modv <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o        = s_q.rdata;
    assign rd_valid_o     = s_q.rd_valid;
    assign irq_o          = s_q.flag && s_q.chie;
    assign hs_req_tgl_o   = s_q.hs_req;
    assign hs_kind_o      = s_q.hs_kind;
    assign hs_data_o      = s_q.hs_data;
    assign snap_ack_tgl_o = s_q.snap_ack;

    // R9: an accepted write makes busy visible on the next cycle
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    // R9: a modulo write while busy leaves the register alone
    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_mod && busy_o) |=> $stable(s_q.modv));

    // R7: writing zero to the flag bit keeps a set flag
    assert_w1c_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_stat && !wdata_i[0] && s_q.flag) |=> s_q.flag);

    // R7: writing one clears the flag when no event arrives together
    assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_stat && wdata_i[0] && !match_evt) |=> !s_q.flag);

    // R10: read data is valid one cycle after the strobe
    assert_rdvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    // R8: interrupt never without the flag
    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> s_q.flag);

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PSC_W  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rd_valid,
    output logic              reg_busy,
    output logic              irq_o
);

    logic              hs_req_tgl, hs_ack_tgl;
    wr_kind_e          hs_kind;
    logic [DATA_W-1:0] hs_data;
    logic              snap_req_tgl, snap_ack_tgl;
    logic [DATA_W-1:0] snap_data;
    logic              match_tgl;

    tmr_bus_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W), .STAGES(STAGES)
    ) u_bus (
        .clk           (bus_clk),
        .rst_n         (bus_rst_n),
        .wr_en_i       (reg_wr_en),
        .rd_en_i       (reg_rd_en),
        .addr_i        (reg_addr),
        .wdata_i       (reg_wdata),
        .rdata_o       (reg_rdata),
        .rd_valid_o    (reg_rd_valid),
        .busy_o        (reg_busy),
        .irq_o         (irq_o),
        .hs_req_tgl_o  (hs_req_tgl),
        .hs_kind_o     (hs_kind),
        .hs_data_o     (hs_data),
        .hs_ack_tgl_i  (hs_ack_tgl),
        .snap_req_tgl_i(snap_req_tgl),
        .snap_data_i   (snap_data),
        .snap_ack_tgl_o(snap_ack_tgl),
        .match_tgl_i   (match_tgl)
    );

    tmr_count_core #(
        .DATA_W(DATA_W), .PSC_W(PSC_W), .STAGES(STAGES)
    ) u_core (
        .clk           (cnt_clk),
        .rst_n         (cnt_rst_n),
        .hs_req_tgl_i  (hs_req_tgl),
        .hs_kind_i     (hs_kind),
        .hs_data_i     (hs_data),
        .hs_ack_tgl_o  (hs_ack_tgl),
        .snap_req_tgl_o(snap_req_tgl),
        .snap_data_o   (snap_data),
        .snap_ack_tgl_i(snap_ack_tgl),
        .match_tgl_o   (match_tgl)
    );

endmodule

// File: tb/tick_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb_top;

    localparam logic [7:0] A_CTRL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18,
                           A_STAT = 8'h1C, A_CHC = 8'h20, A_CHV = 8'h24;
    localparam real CNT_PER = 16.0;

    logic        bus_clk = 1'b0, cnt_clk = 1'b0;
    logic        bus_rst_n = 1'b0, cnt_rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rd_valid, reg_busy, irq_o;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    always #5 bus_clk = ~bus_clk;
    initial begin
        #3;
        forever #(CNT_PER/2) cnt_clk = ~cnt_clk;
    end

    tick_cmp_timer dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rd_valid(reg_rd_valid),
        .reg_busy(reg_busy), .irq_o(irq_o)
    );

    // Monitor: pops expected read results as read data appears
    always @(negedge bus_clk) begin
        if (reg_rd_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R10: unexpected read data %h, expected none", reg_rdata);
            end else begin
                cur = exp_q.pop_front();
                if (reg_rdata < cur.lo || reg_rdata > cur.hi) begin
                    n_err++;
                    $display("FAIL %s: read %h, expected %h..%h", cur.tag, reg_rdata, cur.lo, cur.hi);
                end
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h, expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] lo, input logic [31:0] hi, input string tag);
        exp_q.push_back('{lo: lo, hi: hi, tag: tag});
        @(negedge bus_clk);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        @(negedge bus_clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge bus_clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle();
        while (reg_busy) @(negedge bus_clk);
    endtask

    task automatic wrw(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        idle();
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    // Restart counting from zero with the given control word
    task automatic restart(input logic [31:0] ctrl);
        wrw(A_CTRL, 32'h0);
        wrw(A_CNT, 32'h0);
        wrw(A_CTRL, ctrl);
    endtask

    initial begin
        real t0, t1;
        int  n, e;
        repeat (4) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        cnt_rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        chk({31'b0, irq_o}, 32'h0, "R1 irq after reset");
        chk({31'b0, reg_busy}, 32'h0, "R1 busy after reset");
        rd(A_CTRL, 32'h0, 32'h0, "R1 ctrl reset");
        rd(A_CNT, 32'h0, 32'h0, "R1 count reset");
        rd(A_MOD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 modulo reset");
        rd(A_STAT, 32'h0, 32'h0, "R1 status reset");
        rd(A_CHC, 32'h0, 32'h0, "R1 chctl reset");
        rd(A_CHV, 32'h0, 32'h0, "R1 chval reset");

        // R2: stop mode holds
        wait_cyc(200);
        rd(A_CNT, 32'h0, 32'h0, "R2 stopped count");

        // R2/R3: run at prescale 0 over a measured interval
        wrw(A_CTRL, 32'h08);
        t0 = $realtime;
        wait_cyc(400);
        wrw(A_CTRL, 32'h00);
        t1 = $realtime;
        wait_cyc(30);
        n = int'((t1 - t0) / CNT_PER);
        rd(A_CNT, 32'(n - 5), 32'(n + 4), "R3 prescale 0 count");
        wait_cyc(100);
        rd(A_CNT, 32'(n - 5), 32'(n + 4), "R2 count held after stop");

        // R4: clear by writing the counter register
        wrw(A_CNT, 32'hDEAD_BEEF);
        wait_cyc(30);
        rd(A_CNT, 32'h0, 32'h0, "R4 count cleared");

        // R3: prescale 3 divides by 8
        wrw(A_CTRL, 32'h0B);
        t0 = $realtime;
        wait_cyc(2000);
        wrw(A_CTRL, 32'h00);
        t1 = $realtime;
        wait_cyc(30);
        n = int'((t1 - t0) / CNT_PER) / 8;
        rd(A_CNT, 32'(n - 2), 32'(n + 2), "R3 prescale 3 count");
        rd(A_CTRL, 32'h0, 32'h0, "R10 ctrl readback stopped");

        // R5: modulo 4 keeps the count in 0..4
        wrw(A_MOD, 32'd4);
        restart(32'h08);
        for (int i = 0; i < 12; i++) begin
            wait_cyc(3);
            rd(A_CNT, 32'h0, 32'd4, "R5 count within modulo 4");
        end
        // R5: modulo 0 keeps count at zero
        wrw(A_MOD, 32'd0);
        restart(32'h08);
        wait_cyc(100);
        rd(A_CNT, 32'h0, 32'h0, "R5 modulo zero");

        // R6/R8: compare with full-range modulo
        wrw(A_CTRL, 32'h0);
        wrw(A_MOD, 32'hFFFF_FFFF);
        wrw(A_CHV, 32'd50);
        wrw(A_CHC, 32'h50);
        rd(A_CHC, 32'h50, 32'h50, "R10 chctl readback");
        rd(A_CHV, 32'd50, 32'd50, "R10 chval readback");
        restart(32'h08);
        rd(A_STAT, 32'h0, 32'h0, "R6 no flag before match");
        wait_cyc(200);
        rd(A_STAT, 32'h1, 32'h1, "R6 flag at match");
        chk({31'b0, irq_o}, 32'h1, "R8 irq with flag and enable");

        // R7: write-one-to-clear
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h1, 32'h1, "R7 write zero keeps flag");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, 32'h0, "R7 write one clears flag");
        chk({31'b0, irq_o}, 32'h0, "R8 irq low after clear");
        wait_cyc(200);
        rd(A_STAT, 32'h0, 32'h0, "R6 single set per match");

        // R8: enable bit gates the interrupt
        wrw(A_CHC, 32'h10);
        restart(32'h08);
        wait_cyc(200);
        rd(A_STAT, 32'h1, 32'h1, "R6 flag with enable off");
        chk({31'b0, irq_o}, 32'h0, "R8 irq masked");
        wrw(A_CHC, 32'h50);
        chk({31'b0, irq_o}, 32'h1, "R8 irq after enable set");

        // R6: disabled channel never sets the flag
        wr(A_STAT, 32'h1);
        wrw(A_CHC, 32'h40);
        restart(32'h08);
        wait_cyc(200);
        rd(A_STAT, 32'h0, 32'h0, "R6 channel mode 0 no flag");
        chk({31'b0, irq_o}, 32'h0, "R8 irq stays low mode 0");

        // R5/R6: small modulo gives a match on every pass
        wrw(A_CTRL, 32'h0);
        wrw(A_CHC, 32'h10);
        wrw(A_MOD, 32'd9);
        wrw(A_CHV, 32'd7);
        restart(32'h08);
        wait_cyc(100);
        rd(A_STAT, 32'h1, 32'h1, "R6 first pass match");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, 32'h0, "R7 cleared between passes");
        wait_cyc(100);
        rd(A_STAT, 32'h1, 32'h1, "R5 match again after wrap");

        // R9: busy and drop of a write while busy
        wrw(A_CTRL, 32'h0);
        wr(A_MOD, 32'h0000_1234);
        chk({31'b0, reg_busy}, 32'h1, "R9 busy after write");
        wr(A_MOD, 32'h0000_5678);
        idle();
        chk({31'b0, reg_busy}, 32'h0, "R9 busy released");
        rd(A_MOD, 32'h0000_1234, 32'h0000_1234, "R9 write while busy ignored");

        wait_cyc(5);
        e = exp_q.size();
        if (e != 0) begin
            n_err++;
            $display("FAIL R10: %0d reads produced no data, expected 0", e);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): run not finished, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule